// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps stores in a small circular queue from decode until they are allowed to write the data cache. A slot is handed out in program order when a store is decoded. The slot's address and data then arrive as two independent micro-operations, in either order, each naming the slot by its tag. The reorder logic commits stores oldest first, which clears the speculative flag of the next uncommitted slot. An abort throws away every slot that has not been committed yet. The oldest slot leaves through a cache write port with a valid/ready handshake once it is committed and holds both its address and its data.

A load that is being executed presents its full-word address and the tag of the store allocated just before it. The buffer searches only the slots that are at least as old as that tag. It answers with forwarded data when the youngest such matching store has its data, and with a wait indication when that store has its address but no data yet. A forwarded hit overrides whatever the cache would return. Slots whose address has not arrived are not considered matches.

Top module: `store_fwd_buffer`

## Requirements
- R1: A slot is granted in a cycle when `alloc_valid` is high, `abort_valid` is low and fewer than DEPTH slots are held. `alloc_ready` shows this. The granted tag on `alloc_tag` is the previous grant plus one, modulo 2·DEPTH, and the first grant after reset is 0. The slot index is the low log2(DEPTH) bits of the tag.
- R2: The address and data operations of a slot may arrive in either order. A committed slot that lacks either one is not sent to the cache. Operations that name a slot that is not held, or that repeat a field already present, are ignored.
- R3: `wr_valid` is high only for the oldest slot, and only once that slot is committed and complete. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady. At most one slot drains per cycle, and slots drain in allocation order.
- R4: `cmt_valid` commits the oldest uncommitted slot. A commit when no uncommitted slot is held is ignored and is not remembered.
- R5: `abort_valid` removes all uncommitted slots. An allocation request in the same cycle is refused. The next grant reuses the tag that follows the last committed slot. A removed slot never drains and never forwards.
- R6: A load hits (`ld_hit`=1, `ld_data`=data) when the youngest slot that is at most as young as `ld_age` and whose address equals `ld_addr` holds data.
- R7: Slots younger than `ld_age` are never considered. When the slot named by `ld_age` has already left the buffer, or no store was ever allocated (age = 2·DEPTH−1 after reset), no slot is considered.
- R8: When the youngest eligible matching slot has no data yet, `ld_wait`=1 and `ld_hit`=0, even if an older match holds data.
- R9: With no eligible match, `ld_hit` and `ld_wait` are both 0 and `ld_data` is 0.
- R10: When a commit and an abort fall in the same cycle, the slot being committed survives and later drains.
- R11: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, `wr_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a slot for a decoded store |
| alloc_ready | output | 1 | Slot granted this cycle |
| alloc_tag | output | PW | Tag of the slot being granted |
| sa_valid | input | 1 | Store-address operation |
| sa_slot | input | IW | Slot index of the address operation |
| sa_addr | input | AW | Store address |
| sd_valid | input | 1 | Store-data operation |
| sd_slot | input | IW | Slot index of the data operation |
| sd_data | input | DW | Store data |
| cmt_valid | input | 1 | Commit the oldest uncommitted store |
| abort_valid | input | 1 | Discard all uncommitted stores |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load address |
| ld_age | input | PW | Tag of the store allocated just before the load |
| ld_hit | output | 1 | Forwarded data valid |
| ld_wait | output | 1 | Matching store has no data yet |
| ld_data | output | DW | Forwarded data |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | AW | Cache write address |
| wr_data | output | DW | Cache write data |

## Verification
Commit and abort can coincide, and so can an allocation request and an abort. The bench raises `cmt_valid`, `abort_valid` and `alloc_valid` together while three stores are in flight. It then judges the cycle by three things: the committed store must reach the cache through the scoreboard, `alloc_ready` must read low in that cycle, and the next grant must reuse the tag right after the committed store. A lookup for an aborted store's address must also miss.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  typedef struct packed {
    logic vld;   // slot held
    logic spec;  // not yet committed
    logic a_ok;  // address present
    logic d_ok;  // data present
  } sfb_flags_t;

  // forward distance from one ring position to another
  function automatic int unsigned ring_gap(int unsigned from_p, int unsigned to_p,
                                           int unsigned span);
    return (to_p + span - from_p) % span;
  endfunction

  // a slot can drain when held, committed and complete
  function automatic logic drain_ok(sfb_flags_t f);
    return f.vld & ~f.spec & f.a_ok & f.d_ok;
  endfunction

endpackage

// File: rtl/sfb_ctrl.sv
module sfb_ctrl #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          cmt_valid,
  input  logic          abort_valid,
  input  logic          drain_fire,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] cptr,
  output logic [PW-1:0] tail_ptr,
  output logic [PW-1:0] count,
  output logic          alloc_fire,
  output logic          cmt_fire
);
  import sfb_pkg::*;

  localparam logic [PW-1:0] ONE = PW'(1);
  logic [PW-1:0] cptr_nx;
  logic          full;

  always_comb begin
    count      = PW'(ring_gap(32'(head_ptr), 32'(tail_ptr), 2 * DEPTH));
    full       = (count == PW'(DEPTH));
    alloc_fire = alloc_valid & ~full & ~abort_valid;
    cmt_fire   = cmt_valid & (cptr != tail_ptr);
    cptr_nx    = cmt_fire ? cptr + ONE : cptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      cptr     <= '0;
      tail_ptr <= '0;
    end else begin
      if (drain_fire) head_ptr <= head_ptr + ONE;
      cptr <= cptr_nx;
      if (abort_valid)     tail_ptr <= cptr_nx;
      else if (alloc_fire) tail_ptr <= tail_ptr + ONE;
    end
  end

endmodule

// File: rtl/sfb_slots.sv
module sfb_slots #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_fire,
  input  logic [IW-1:0]       tail_idx,
  input  logic                cmt_fire,
  input  logic [IW-1:0]       cptr_idx,
  input  logic                abort_valid,
  input  logic                drain_fire,
  input  logic [IW-1:0]       head_idx,
  input  logic                sa_valid,
  input  logic [IW-1:0]       sa_slot,
  input  logic [AW-1:0]       sa_addr,
  input  logic                sd_valid,
  input  logic [IW-1:0]       sd_slot,
  input  logic [DW-1:0]       sd_data,
  output sfb_pkg::sfb_flags_t flags [DEPTH],
  output logic [AW-1:0]       addr  [DEPTH],
  output logic [DW-1:0]       data  [DEPTH]
);
  import sfb_pkg::*;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic take, sa_hit, sd_hit, cmt_hit, kill;

    always_comb begin
      take    = alloc_fire & (tail_idx == IW'(i));
      sa_hit  = sa_valid & (sa_slot == IW'(i)) & flags[i].vld & ~flags[i].a_ok;
      sd_hit  = sd_valid & (sd_slot == IW'(i)) & flags[i].vld & ~flags[i].d_ok;
      cmt_hit = cmt_fire & (cptr_idx == IW'(i));
      kill    = (abort_valid & flags[i].spec & ~cmt_hit)
              | (drain_fire & (head_idx == IW'(i)));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= '0;
        addr[i]  <= '0;
        data[i]  <= '0;
      end else if (take) begin
        flags[i] <= '{vld: 1'b1, spec: 1'b1, a_ok: 1'b0, d_ok: 1'b0};
      end else if (kill) begin
        flags[i] <= '0;
      end else begin
        if (sa_hit) begin
          flags[i].a_ok <= 1'b1;
          addr[i]       <= sa_addr;
        end
        if (sd_hit) begin
          flags[i].d_ok <= 1'b1;
          data[i]       <= sd_data;
        end
        if (cmt_hit) flags[i].spec <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sfb_match.sv
module sfb_match #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  sfb_pkg::sfb_flags_t flags [DEPTH],
  input  logic [AW-1:0]       addr  [DEPTH],
  input  logic [DW-1:0]       data  [DEPTH],
  input  logic [PW-1:0]       head_ptr,
  input  logic [PW-1:0]       count,
  input  logic                ld_valid,
  input  logic [AW-1:0]       ld_addr,
  input  logic [PW-1:0]       ld_age,
  output logic                ld_hit,
  output logic                ld_wait,
  output logic [DW-1:0]       ld_data
);
  import sfb_pkg::*;

  logic [PW-1:0] ld_dist;
  logic          in_buf;
  logic          found;
  logic [IW-1:0] best;
  logic [IW-1:0] head_idx;

  assign head_idx = head_ptr[IW-1:0];

  always_comb begin
    ld_dist = PW'(ring_gap(32'(head_ptr), 32'(ld_age), 2 * DEPTH));
    in_buf  = (ld_dist < count);
    found   = 1'b0;
    best    = '0;
    // walk oldest to youngest; a later match overrides an earlier one
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] s;
      s = IW'(32'(head_idx) + 32'(k));
      if (in_buf && (PW'(k) <= ld_dist) && flags[s].vld && flags[s].a_ok
          && (addr[s] == ld_addr)) begin
        found = 1'b1;
        best  = s;
      end
    end
    ld_hit  = ld_valid & found & flags[best].d_ok;
    ld_wait = ld_valid & found & ~flags[best].d_ok;
    ld_data = ld_hit ? data[best] : '0;
  end

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [PW-1:0] alloc_tag,
  input  logic          sa_valid,
  input  logic [IW-1:0] sa_slot,
  input  logic [AW-1:0] sa_addr,
  input  logic          sd_valid,
  input  logic [IW-1:0] sd_slot,
  input  logic [DW-1:0] sd_data,
  input  logic          cmt_valid,
  input  logic          abort_valid,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [PW-1:0] ld_age,
  output logic          ld_hit,
  output logic          ld_wait,
  output logic [DW-1:0] ld_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  import sfb_pkg::*;

  logic [PW-1:0] head_ptr, cptr, tail_ptr, count;
  logic          alloc_fire, cmt_fire, drain_fire;
  sfb_flags_t    flags [DEPTH];
  logic [AW-1:0] addr  [DEPTH];
  logic [DW-1:0] data  [DEPTH];
  logic [IW-1:0] head_idx;

  assign head_idx    = head_ptr[IW-1:0];
  assign alloc_ready = alloc_fire;
  assign alloc_tag   = tail_ptr;
  assign wr_valid    = drain_ok(flags[head_idx]);
  assign wr_addr     = addr[head_idx];
  assign wr_data     = data[head_idx];
  assign drain_fire  = wr_valid & wr_ready;

  sfb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst_n, .alloc_valid, .cmt_valid, .abort_valid, .drain_fire,
    .head_ptr, .cptr, .tail_ptr, .count, .alloc_fire, .cmt_fire
  );

  sfb_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
    .clk, .rst_n, .alloc_fire, .tail_idx(tail_ptr[IW-1:0]),
    .cmt_fire, .cptr_idx(cptr[IW-1:0]), .abort_valid, .drain_fire,
    .head_idx, .sa_valid, .sa_slot, .sa_addr, .sd_valid, .sd_slot, .sd_data,
    .flags, .addr, .data
  );

  sfb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .flags, .addr, .data, .head_ptr, .count, .ld_valid, .ld_addr, .ld_age,
    .ld_hit, .ld_wait, .ld_data
  );

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [PW-1:0] alloc_tag,
  input logic          abort_valid,
  input logic          ld_valid,
  input logic [PW-1:0] ld_age,
  input logic          ld_hit,
  input logic          ld_wait,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [PW-1:0] head_ptr,
  input logic [PW-1:0] cptr,
  input logic [PW-1:0] tail_ptr
);

  a_r1_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(tail_ptr - head_ptr) <= PW'(DEPTH));

  a_r1_no_grant_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (PW'(tail_ptr - head_ptr) == PW'(DEPTH)) |-> !alloc_ready);

  a_r1_tag_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_tag == PW'($past(alloc_tag) + PW'(1))));

  a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r4_commit_window: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(cptr - head_ptr) <= PW'(tail_ptr - head_ptr));

  a_r5_abort_trims: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |=> (tail_ptr == cptr));

  a_r5_abort_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> !alloc_ready);

  a_r7_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (PW'(ld_age - head_ptr) >= PW'(tail_ptr - head_ptr)))
      |-> (!ld_hit && !ld_wait));

  a_r8_hit_wait_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_wait));

endmodule

bind store_fwd_buffer sfb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sfb_checker (
  .clk, .rst_n, .alloc_valid, .alloc_ready, .alloc_tag, .abort_valid,
  .ld_valid, .ld_age, .ld_hit, .ld_wait, .wr_valid, .wr_ready, .wr_addr, .wr_data,
  .head_ptr, .cptr, .tail_ptr
);

// File: tb/test_store_fwd_buffer.sv
module test_store_fwd_buffer;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0, sa_valid = 1'b0, sd_valid = 1'b0;
  logic          cmt_valid = 1'b0, abort_valid = 1'b0, ld_valid = 1'b0;
  logic          wr_ready = 1'b1;
  logic [IW-1:0] sa_slot = '0, sd_slot = '0;
  logic [AW-1:0] sa_addr = '0, ld_addr = '0;
  logic [DW-1:0] sd_data = '0;
  logic [PW-1:0] ld_age = '0;
  logic          alloc_ready, ld_hit, ld_wait, wr_valid;
  logic [PW-1:0] alloc_tag;
  logic [DW-1:0] ld_data, wr_data;
  logic [AW-1:0] wr_addr;

  store_fwd_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_fwd_buffer (.*);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [PW-1:0] exp_tag = '0;
  logic [AW-1:0] m_addr [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  bit            m_dok  [DEPTH];
  int            exp_q [$];
  bit            done = 1'b0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_alloc(output logic [PW-1:0] t);
    alloc_valid = 1'b1;
    #1;
    chk(alloc_ready == 1'b1, "R1", "alloc_ready", alloc_ready, 1);
    chk(alloc_tag == exp_tag, "R1", "alloc_tag", alloc_tag, exp_tag);
    t = alloc_tag;
    m_dok[t[IW-1:0]] = 1'b0;
    exp_tag = exp_tag + PW'(1);
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic do_sa(logic [PW-1:0] t, logic [AW-1:0] a);
    sa_valid = 1'b1; sa_slot = t[IW-1:0]; sa_addr = a;
    m_addr[t[IW-1:0]] = a;
    step();
    sa_valid = 1'b0;
  endtask

  task automatic do_sd(logic [PW-1:0] t, logic [DW-1:0] d);
    sd_valid = 1'b1; sd_slot = t[IW-1:0]; sd_data = d;
    m_data[t[IW-1:0]] = d; m_dok[t[IW-1:0]] = 1'b1;
    step();
    sd_valid = 1'b0;
  endtask

  task automatic do_commit(logic [PW-1:0] t);
    cmt_valid = 1'b1;
    exp_q.push_back(int'(t[IW-1:0]));
    step();
    cmt_valid = 1'b0;
  endtask

  task automatic look(logic [AW-1:0] a, logic [PW-1:0] age, bit eh, bit ew,
                      logic [DW-1:0] ed, string rq);
    ld_valid = 1'b1; ld_addr = a; ld_age = age;
    #1;
    chk(ld_hit == eh, rq, "ld_hit", ld_hit, eh);
    chk(ld_wait == ew, rq, "ld_wait", ld_wait, ew);
    chk(ld_data == ed, rq, "ld_data", ld_data, ed);
    ld_valid = 1'b0;
  endtask

  task automatic drain_all();
    for (int i = 0; i < 30 && exp_q.size() != 0; i++) step();
    step();
    chk(exp_q.size() == 0, "R3", "pending drains", exp_q.size(), 0);
  endtask

  // scoreboard monitor: every cache write must be the next committed store
  always begin
    @(negedge clk);
    #3;
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected drain addr", wr_addr, 0);
      end else begin
        int s;
        s = exp_q.pop_front();
        chk(m_dok[s], "R2", "drain before data", 0, 1);
        chk(wr_addr == m_addr[s], "R3", "wr_addr", wr_addr, m_addr[s]);
        chk(wr_data == m_data[s], "R3", "wr_data", wr_data, m_data[s]);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] t0, t1, t2, t3, t4, t5, t6, tx;
    logic [PW-1:0] tags [DEPTH];
    for (int i = 0; i < DEPTH; i++) begin m_addr[i] = '0; m_data[i] = '0; m_dok[i] = 0; end
    repeat (3) step();
    rst_n = 1'b1;
    alloc_valid = 1'b1;
    #1;
    // R11 reset state
    chk(alloc_ready == 1'b1, "R11", "alloc_ready", alloc_ready, 1);
    chk(alloc_tag == '0, "R11", "alloc_tag", alloc_tag, 0);
    chk(wr_valid == 1'b0, "R11", "wr_valid", wr_valid, 0);
    alloc_valid = 1'b0;
    look(32'h100, PW'(2 * DEPTH - 1), 0, 0, 0, "R7");
    step();

    // R2: fields in either order
    do_alloc(t0); do_alloc(t1); do_alloc(t2);
    do_sa(t0, 32'h100);
    do_sd(t1, 32'h11);
    do_sa(t1, 32'h100);
    do_sa(t2, 32'h200); do_sd(t2, 32'h22);
    do_sd(t0, 32'h10);
    look(32'h100, t2, 1, 0, 32'h11, "R6");
    look(32'h100, t0, 1, 0, 32'h10, "R7");
    look(32'h200, t1, 0, 0, 0, "R7");
    look(32'h300, t2, 0, 0, 0, "R9");
    step();
    do_alloc(t3);
    do_sa(t3, 32'h100);
    look(32'h100, t3, 0, 1, 0, "R8");
    look(32'h100, t2, 1, 0, 32'h11, "R6");

    // R3: stalled cache keeps the request steady
    wr_ready = 1'b0;
    do_commit(t0);
    #1;
    chk(wr_valid == 1'b1, "R3", "wr_valid", wr_valid, 1);
    chk(wr_addr == 32'h100, "R3", "wr_addr", wr_addr, 32'h100);
    for (int i = 0; i < 3; i++) begin
      step(); #1;
      chk(wr_valid == 1'b1 && wr_data == 32'h10, "R3", "held wr_data", wr_data, 32'h10);
    end
    wr_ready = 1'b1;
    do_commit(t1);
    do_commit(t2);
    drain_all();
    look(32'h200, t2, 0, 0, 0, "R7");

    // R2: committed but incomplete slot stays
    do_commit(t3);
    repeat (3) step();
    #1;
    chk(wr_valid == 1'b0, "R2", "wr_valid without data", wr_valid, 0);
    step();
    do_sd(t3, 32'h33);
    drain_all();

    // R10 / R5: commit, abort and allocation together
    do_alloc(t4); do_alloc(t5); do_alloc(t6);
    do_sa(t4, 32'h400); do_sd(t4, 32'h44);
    do_sa(t5, 32'h500); do_sd(t5, 32'h55);
    do_sa(t6, 32'h600); do_sd(t6, 32'h66);
    cmt_valid = 1'b1; abort_valid = 1'b1; alloc_valid = 1'b1;
    exp_q.push_back(int'(t4[IW-1:0]));
    #1;
    chk(alloc_ready == 1'b0, "R5", "alloc_ready during abort", alloc_ready, 0);
    step();
    cmt_valid = 1'b0; abort_valid = 1'b0; alloc_valid = 1'b0;
    exp_tag = t4 + PW'(1);
    drain_all();  // R10: t4 must arrive at the cache
    look(32'h500, t6, 0, 0, 0, "R5");

    // R4: stray commit on empty buffer is dropped
    cmt_valid = 1'b1; step(); cmt_valid = 1'b0;
    do_sa(t5, 32'h700);            // R5: slot no longer held, ignored
    do_alloc(tx);
    chk(tx == t5, "R5", "reused tag", tx, t5);
    look(32'h700, tx, 0, 0, 0, "R5");
    do_sa(tx, 32'h800); do_sd(tx, 32'h88);
    look(32'h800, tx, 1, 0, 32'h88, "R6");
    repeat (3) step();
    #1;
    chk(wr_valid == 1'b0, "R4", "wr_valid after stray commit", wr_valid, 0);
    step();
    do_commit(tx);
    drain_all();

    // R1: fill to DEPTH, then refuse
    for (int i = 0; i < DEPTH; i++) do_alloc(tags[i]);
    alloc_valid = 1'b1;
    #1;
    chk(alloc_ready == 1'b0, "R1", "alloc_ready when full", alloc_ready, 0);
    step();
    alloc_valid = 1'b0;
    abort_valid = 1'b1; step(); abort_valid = 1'b0;
    exp_tag = tags[0];
    do_alloc(tx);
    chk(tx == tags[0], "R5", "tag after full abort", tx, tags[0]);
    abort_valid = 1'b1; step(); abort_valid = 1'b0;
    exp_tag = tags[0];
    repeat (3) step();
    chk(exp_q.size() == 0, "R5", "aborted slots drained", exp_q.size(), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule